// File: doc/BRIEF.md
# Asynchronous Interrupt Priority Arbiter

This block sits in front of a processor's exception entry logic and decides when an asynchronous event should redirect the instruction stream. It watches three sources: a pending floating-point enabled exception (any of the exception mode bits set while the exception summary flag is high), a level-sensitive external interrupt line, and a single-cycle decrementer event. It tracks which of them are pending, picks one by fixed priority, and presents one request at a time. Each request carries the entry vector and the two bits that the entry logic merges into save/restore register 1.

The external and decrementer sources are gated by the external-interrupt enable. The floating-point source is not. The external pending bit copies the input line, so an external request that is delivered and acknowledged while the line is still high is requested again. A decrementer event is remembered until its own delivery is acknowledged, which consumes it. The enable, mode and summary inputs are looked at again on every idle cycle, so a request that becomes enabled is scheduled without any further event.

A small state machine controls scheduling. ST_IDLE evaluates the selector every cycle. The transition IDLE→ISSUE is taken when the selector finds a source, and the vector and bits are latched on that transition. ST_ISSUE holds the request until `ack`. The transition ISSUE→COOL is taken on `ack` and consumes a decrementer source. ST_COOL lasts exactly one cycle with no request, and the transition COOL→IDLE always follows.

Top module: `irq_arbiter`

## Requirements
- R1: After reset `req_valid` is 0 and neither the external nor the decrementer source is pending.
- R2: When `fp_mode` is nonzero and `fp_exc_sum` is 1, the floating-point source wins over every other source, whatever `ext_en` is. It requests vector 0x700 with `req_save_bits` = 2'b11 (bit 1 marks the enabled floating-point exception, bit 0 marks the subsequent-instruction case). When `fp_mode` is 0, `fp_exc_sum` alone raises no request.
- R3: The external and decrementer sources raise a request only while `ext_en` is 1.
- R4: When both are pending and enabled, the external source goes before the decrementer. It requests vector 0x500 with `req_save_bits` = 2'b00.
- R5: The external pending bit follows `ext_line` one cycle late. Delivery does not clear it, so a line still high after an acknowledge raises a new request. A line that drops while `ext_en` is 0 leaves nothing pending.
- R6: A one-cycle `dec_event` pulse makes the decrementer pending. It requests vector 0x900 with `req_save_bits` = 2'b00. Acknowledging that delivery clears it, so one event gives exactly one delivery. An acknowledge of some other source leaves it pending.
- R7: At most one request is outstanding. While `req_valid` is 1 and `ack` is 0, `req_valid`, `req_vector` and `req_save_bits` stay unchanged, even if the inputs change.
- R8: In the cycle after an acknowledge, `req_valid` is 0.
- R9: A source that is pending while disabled stays pending indefinitely and gives no request. Once it becomes enabled, exactly one request is raised.
- R10: From idle, `req_valid` rises on the clock edge at which the selecting condition is first sampled. For the external line this means two edges after the line rises, because the line first passes through its pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_line | input | 1 | Level-sensitive external interrupt line |
| dec_event | input | 1 | One-cycle decrementer expiry pulse |
| ext_en | input | 1 | External-interrupt enable |
| fp_mode | input | MODE_W | Floating-point exception mode bits |
| fp_exc_sum | input | 1 | Floating-point enabled-exception summary flag |
| ack | input | 1 | Exception entry logic has taken the request |
| req_valid | output | 1 | A delivery request is outstanding |
| req_vector | output | VEC_W | Entry vector of the outstanding request |
| req_save_bits | output | 2 | Bits to merge into save/restore register 1 (bit 1 fp enabled, bit 0 subsequent instruction) |

## Verification
The assertions assume that `ack` is raised only while `req_valid` is 1, and for one cycle at a time. They also assume that `dec_event` is a single-cycle pulse that does not coincide with the acknowledge of a decrementer delivery. The stimulus keeps to these rules. It drives every input one nanosecond after a rising edge, pulses `dec_event` for exactly one cycle, and raises `ack` only after it has seen `req_valid` high, holding it for one cycle. While a request is being held, the floating-point flag, the enable and the external line are changed on purpose, to show that the outstanding request does not move.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // Source selected by the priority logic
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FP   = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_DEC  = 2'd3
    } src_e;

    // Scheduling state machine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_COOL  = 2'd2
    } state_e;

    // Save/restore register 1 bits carried with a request
    localparam int SAVE_W      = 2;
    localparam int SAVE_FPEN   = 1;
    localparam int SAVE_SUBSEQ = 0;

    localparam int NUM_SRC = 3;

endpackage

// File: rtl/irq_pending_track.sv
module irq_pending_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_line,
    input  logic dec_event,
    input  logic dec_consume,
    output logic ext_pend,
    output logic dec_pend
);

    // External pending copies the level; decrementer is sticky until consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_pend <= 1'b0;
            dec_pend <= 1'b0;
        end else begin
            ext_pend <= ext_line;
            if (dec_event)
                dec_pend <= 1'b1;
            else if (dec_consume)
                dec_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_arb_pkg::*;
#(
    parameter int MODE_W = 2
) (
    input  logic              ext_en,
    input  logic [MODE_W-1:0] fp_mode,
    input  logic              fp_exc_sum,
    input  logic              ext_pend,
    input  logic              dec_pend,
    output src_e              sel,
    output logic [NUM_SRC-1:0] grant
);

    logic fp_hit;
    logic ext_hit;
    logic dec_hit;

    always_comb begin
        fp_hit  = (|fp_mode) && fp_exc_sum;
        ext_hit = ext_en && ext_pend;
        dec_hit = ext_en && dec_pend;
        grant   = '0;
        sel     = SRC_NONE;
        if (fp_hit) begin
            sel      = SRC_FP;
            grant[0] = 1'b1;
        end else if (ext_hit) begin
            sel      = SRC_EXT;
            grant[1] = 1'b1;
        end else if (dec_hit) begin
            sel      = SRC_DEC;
            grant[2] = 1'b1;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int               VEC_W   = 12,
    parameter int               MODE_W  = 2,
    parameter logic [VEC_W-1:0] VEC_FP  = 12'h700,
    parameter logic [VEC_W-1:0] VEC_EXT = 12'h500,
    parameter logic [VEC_W-1:0] VEC_DEC = 12'h900
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_line,
    input  logic              dec_event,
    input  logic              ext_en,
    input  logic [MODE_W-1:0] fp_mode,
    input  logic              fp_exc_sum,
    input  logic              ack,
    output logic              req_valid,
    output logic [VEC_W-1:0]  req_vector,
    output logic [SAVE_W-1:0] req_save_bits
);

    state_e             state_q;
    state_e             state_d;
    src_e               sel;
    src_e               cur_src;
    logic [NUM_SRC-1:0] grant;
    logic               ext_pend;
    logic               dec_pend;
    logic               dec_consume;
    logic               issue;

    irq_pending_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_line    (ext_line),
        .dec_event   (dec_event),
        .dec_consume (dec_consume),
        .ext_pend    (ext_pend),
        .dec_pend    (dec_pend)
    );

    irq_prio_select #(.MODE_W(MODE_W)) u_sel (
        .ext_en     (ext_en),
        .fp_mode    (fp_mode),
        .fp_exc_sum (fp_exc_sum),
        .ext_pend   (ext_pend),
        .dec_pend   (dec_pend),
        .sel        (sel),
        .grant      (grant)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sel != SRC_NONE) state_d = ST_ISSUE;
            ST_ISSUE: if (ack)             state_d = ST_COOL;
            ST_COOL:                       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    assign issue       = (state_q == ST_IDLE) && (sel != SRC_NONE);
    assign dec_consume = (state_q == ST_ISSUE) && ack && (cur_src == SRC_DEC);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output register: payload latched at issue and frozen until acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_src       <= SRC_NONE;
            req_vector    <= '0;
            req_save_bits <= '0;
        end else if (issue) begin
            cur_src <= sel;
            unique case (sel)
                SRC_FP: begin
                    req_vector                 <= VEC_FP;
                    req_save_bits              <= '0;
                    req_save_bits[SAVE_FPEN]   <= 1'b1;
                    req_save_bits[SAVE_SUBSEQ] <= 1'b1;
                end
                SRC_EXT: begin
                    req_vector    <= VEC_EXT;
                    req_save_bits <= '0;
                end
                SRC_DEC: begin
                    req_vector    <= VEC_DEC;
                    req_save_bits <= '0;
                end
                default: begin
                    req_vector    <= req_vector;
                    req_save_bits <= req_save_bits;
                end
            endcase
        end
    end

    assign req_valid = (state_q == ST_ISSUE);

    // R7: outstanding request frozen until acknowledged
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ack) |=> (req_valid && $stable(req_vector) && $stable(req_save_bits)));

    // R8: gap cycle after acknowledge
    assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ack) |=> !req_valid);

    // R2: floating-point source wins when it was asserted at issue
    assert_fp_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && $past((|fp_mode) && fp_exc_sum)) |-> (req_vector == VEC_FP));

    // R3: external and decrementer requests need the enable
    assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && req_vector != VEC_FP) |-> $past(ext_en));

    // R4: selector never grants two sources at once
    assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6: acknowledged decrementer delivery leaves nothing pending
    assert_dec_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ack && cur_src == SRC_DEC && !dec_event) |=> !dec_pend);

endmodule

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;

    localparam int VEC_W  = 12;
    localparam int MODE_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ext_line = 1'b0;
    logic              dec_event = 1'b0;
    logic              ext_en = 1'b0;
    logic [MODE_W-1:0] fp_mode = '0;
    logic              fp_exc_sum = 1'b0;
    logic              ack = 1'b0;
    logic              req_valid;
    logic [VEC_W-1:0]  req_vector;
    logic [1:0]        req_save_bits;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [13:0] exp_q[$];

    always #2 clk = ~clk;

    irq_arbiter dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_line      (ext_line),
        .dec_event     (dec_event),
        .ext_en        (ext_en),
        .fp_mode       (fp_mode),
        .fp_exc_sum    (fp_exc_sum),
        .ack           (ack),
        .req_valid     (req_valid),
        .req_vector    (req_vector),
        .req_save_bits (req_save_bits)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [11:0] v, input logic [1:0] b);
        exp_q.push_back({v, b});
    endtask

    // Monitor: compares each new request with the scoreboard, checks hold and gap
    logic              pv = 1'b0;
    logic              pa = 1'b0;
    logic [VEC_W-1:0]  lv = '0;
    logic [1:0]        lb = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_valid && !pv) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected request", {18'd0, req_vector, req_save_bits}, 32'd0);
                end else begin
                    logic [13:0] e;
                    e = exp_q.pop_front();
                    chk({req_vector, req_save_bits} == e, "R2/R4/R6 request payload",
                        {18'd0, req_vector, req_save_bits}, {18'd0, e});
                end
            end
            if (req_valid && pv && !pa)
                chk(req_vector == lv && req_save_bits == lb, "R7 held payload",
                    {18'd0, req_vector, req_save_bits}, {18'd0, lv, lb});
            if (pv && pa)
                chk(!req_valid, "R8 gap after ack", {31'd0, req_valid}, 32'd0);
        end
        pv = req_valid;
        pa = ack;
        lv = req_vector;
        lb = req_save_bits;
    end

    task automatic serve(input int hold);
        for (int i = 0; i < 60 && !req_valid; i++) @(negedge clk);
        chk(req_valid, "R7 request present before ack", {31'd0, req_valid}, 32'd1);
        repeat (hold) @(negedge clk);
        @(posedge clk); #1 ack = 1'b1;
        @(posedge clk); #1 ack = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!req_valid, tag, {31'd0, req_valid}, 32'd0);
        end
    endtask

    task automatic dec_pulse;
        tick; dec_event = 1'b1;
        tick; dec_event = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!req_valid, "R1 reset no request", {31'd0, req_valid}, 32'd0);
        tick; rst_n = 1'b1;
        quiet(4, "R1 idle after reset with nothing pending");

        // R2 + R10: fp source, mode bit 0, enable low; latency one edge
        push(12'h700, 2'b11);
        tick; fp_mode = 2'b01; fp_exc_sum = 1'b1;
        @(negedge clk); chk(!req_valid, "R10 fp not before edge", {31'd0, req_valid}, 32'd0);
        @(negedge clk); chk(req_valid, "R10 fp request after one edge", {31'd0, req_valid}, 32'd1);
        tick; fp_exc_sum = 1'b0;           // R7: change input while held
        serve(4);
        quiet(6, "R2 no repeat after fp cleared");

        // R2: other mode bit
        push(12'h700, 2'b11);
        tick; fp_mode = 2'b10; fp_exc_sum = 1'b1;
        repeat (3) @(negedge clk);
        tick; fp_exc_sum = 1'b0;
        serve(1);
        // R2: summary flag without mode bits
        tick; fp_mode = 2'b00; fp_exc_sum = 1'b1;
        quiet(8, "R2 summary without mode ignored");
        tick; fp_exc_sum = 1'b0;

        // R3/R9: external held while disabled, then enabled
        tick; ext_line = 1'b1;
        quiet(20, "R9 external pending while disabled");
        push(12'h500, 2'b00);
        tick; ext_en = 1'b1;
        @(negedge clk); chk(!req_valid, "R10 ext not before edge", {31'd0, req_valid}, 32'd0);
        @(negedge clk); chk(req_valid, "R9 ext delivered once enabled", {31'd0, req_valid}, 32'd1);
        serve(2);
        // R5: line still high -> requested again
        push(12'h500, 2'b00);
        for (int i = 0; i < 10 && !req_valid; i++) @(negedge clk);
        chk(req_valid, "R5 level line re-requested", {31'd0, req_valid}, 32'd1);
        tick; ext_line = 1'b0;
        serve(3);
        quiet(8, "R5 no request after line dropped");

        // R10: external latency from line rise with enable high
        push(12'h500, 2'b00);
        tick; ext_line = 1'b1;
        @(negedge clk); chk(!req_valid, "R10 ext edge 0", {31'd0, req_valid}, 32'd0);
        @(negedge clk); chk(!req_valid, "R10 ext edge 1", {31'd0, req_valid}, 32'd0);
        @(negedge clk); chk(req_valid, "R10 ext edge 2", {31'd0, req_valid}, 32'd1);
        tick; ext_line = 1'b0;
        serve(1);
        quiet(6, "R5 external cleared");

        // R6: decrementer one-shot; enable dropped while held (R7)
        push(12'h900, 2'b00);
        dec_pulse();
        for (int i = 0; i < 10 && !req_valid; i++) @(negedge clk);
        tick; ext_en = 1'b0;
        serve(3);
        tick; ext_en = 1'b1;
        quiet(10, "R6 decrementer consumed");

        // R4: both pending, external first, decrementer kept
        tick; ext_en = 1'b0; ext_line = 1'b1;
        dec_pulse();
        quiet(5, "R3 disabled sources silent");
        push(12'h500, 2'b00);
        push(12'h900, 2'b00);
        tick; ext_en = 1'b1;
        for (int i = 0; i < 10 && !req_valid; i++) @(negedge clk);
        tick; ext_line = 1'b0;
        serve(2);
        serve(2);
        quiet(8, "R6 single decrementer delivery");

        // R2 over external
        tick; ext_en = 1'b0; ext_line = 1'b1;
        repeat (3) tick;
        push(12'h700, 2'b11);
        push(12'h500, 2'b00);
        tick; ext_en = 1'b1; fp_mode = 2'b01; fp_exc_sum = 1'b1;
        for (int i = 0; i < 10 && !req_valid; i++) @(negedge clk);
        tick; fp_exc_sum = 1'b0;
        serve(2);
        for (int i = 0; i < 10 && !req_valid; i++) @(negedge clk);
        tick; ext_line = 1'b0;
        serve(2);
        quiet(6, "R4 all served");

        // R5: line dropped while disabled leaves nothing
        tick; ext_en = 1'b0; ext_line = 1'b1;
        repeat (3) tick;
        ext_line = 1'b0;
        repeat (3) tick;
        ext_en = 1'b1;
        quiet(10, "R5 dropped line not pending");

        chk(exp_q.size() == 0, "R9 all expected requests seen", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule